// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initializer

This block runs the fixed power-up sequence a DDR SDRAM needs before it can accept traffic. It sits idle, with clock enable low and the command bus quiet, until software writes a configuration word with its start bit set. The same write supplies the burst length and the CAS latency. The block then holds clock enable low for a programmable number of cycles, which covers the 200 µs stabilisation delay. After that it raises clock enable and issues the initialization commands with a fixed spacing: precharge-all, extended mode set (DLL on), mode set with DLL reset, precharge-all, two auto refreshes, and a final mode set with the DLL reset bit cleared. It then waits a DLL lock interval and raises a ready flag.

User read and write requests are gated by that flag. Before ready, a request is refused. After ready, it is granted in the same cycle. The command pins use the usual active-low row-strobe, column-strobe and write-enable truth table. The mode word is built from the programmed settings, including the half-cycle CAS latencies.

Top module: `ddr_init_seq`

## Requirements
- R1: During and right after reset, `mem_cke` is 0, the command is NOP ({ras_n,cas_n,we_n}=111), `mem_ba` and `mem_addr` are 0, and `init_ready` is 0.
- R2: In idle, a `cfg_wr` with `cfg_data[7]`=0 starts nothing: clock enable stays low and no command is issued. A `cfg_wr` with `cfg_data[7]`=1 starts the sequence. The cycle after the write is cycle k=0.
- R3: From k=0 to k=PWR_CYC-1, `mem_cke` is 0 and the bus is NOP. From k=PWR_CYC on, `mem_cke` is 1 and stays 1.
- R4: Command n (n=1..7) lasts one cycle at k=PWR_CYC+n*CMD_GAP. Every other cycle is NOP. The order is: precharge-all, extended mode set, mode set with DLL reset, precharge-all, refresh, refresh, mode set.
- R5: Pin encodings {ras_n,cas_n,we_n}: precharge 010 with addr bit 10 = 1 and all other address bits 0; refresh 001 with address 0; mode set 000. The extended mode set uses ba=01 and address 0, which enables the DLL. The mode set uses ba=00. On NOP, ba and address are 0.
- R6: The burst length comes from `cfg_data[3:0]`, given in beats. It is placed in mode word bits [2:0] as 2→001 and 4→010. Every other value is treated as 8→011. Bit 3 of the mode word is 0 (sequential bursts).
- R7: The CAS latency comes from `cfg_data[6:4]`, given in half clocks. It is placed in mode word bits [6:4] as 3 (1.5)→101, 4 (2.0)→010 and 5 (2.5)→110. Every other value is treated as 3.0→011. Bit 8 is 1 on the first mode set and 0 on the final one. All other address bits are 0.
- R8: `init_ready` rises at k=PWR_CYC+8*CMD_GAP+DLL_CYC and stays high until reset. While it is high, the bus stays NOP.
- R9: `usr_reject` = `usr_req` while not ready, and `usr_grant` = `usr_req` while ready, both in the same cycle. The two are never high together.
- R10: A `cfg_wr` that arrives while the sequence runs, or after ready, is ignored. Timing, mode word and the ready state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | [7] start, [6:4] CAS in half clocks, [3:0] burst length in beats |
| usr_req | input | 1 | User read/write request |
| usr_grant | output | 1 | Request accepted |
| usr_reject | output | 1 | Request refused (not initialized) |
| init_ready | output | 1 | Initialization complete |
| mem_cke | output | 1 | Memory clock enable |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | ADDR_W | Address / mode word |

## Verification
The assertions check, on every cycle, the rules that hold at any moment:
- the bus is quiet while clock enable is low or ready is high;
- clock enable and ready never fall once raised;
- grant and reject follow ready;
- a base mode word carries only legal burst and latency codes;
- two commands are never adjacent.

Only the bench scenarios can show the rest. That covers the exact cycle of each command, the order of the sequence, the mapping from the programmed values to the mode word, and that a late configuration write leaves a run untouched. The bench checks these against a cycle-by-cycle model of the whole sequence.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W  = 13,
  parameter int PWR_CYC = 40000,
  parameter int CMD_GAP = 4,
  parameter int DLL_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_data,
  input  logic              usr_req,
  output logic              usr_grant,
  output logic              usr_reject,
  output logic              init_ready,
  output logic              mem_cke,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_ba,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int MAX_AB = (PWR_CYC > DLL_CYC) ? PWR_CYC : DLL_CYC;
  localparam int MAX_C  = (MAX_AB > CMD_GAP) ? MAX_AB : CMD_GAP;
  localparam int CW     = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_PWR, S_SEQ, S_DLL, S_RDY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic [3:0]    bl_r;
  logic [2:0]    cas_r;
  logic [2:0]    bl_code, cas_code;
  logic          slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      step  <= '0;
      bl_r  <= 4'd8;
      cas_r <= 3'd6;
    end else begin
      case (st)
        S_IDLE: if (cfg_wr) begin
          bl_r  <= cfg_data[3:0];
          cas_r <= cfg_data[6:4];
          cnt   <= '0;
          if (cfg_data[7]) st <= S_PWR;
        end
        S_PWR: if (cnt == CW'(PWR_CYC - 1)) begin
          st   <= S_SEQ;
          cnt  <= '0;
          step <= '0;
        end else cnt <= cnt + 1'b1;
        S_SEQ: if (cnt == CW'(CMD_GAP - 1)) begin
          cnt <= '0;
          if (step == 3'd7) st <= S_DLL;
          else step <= step + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_DLL: if (cnt == CW'(DLL_CYC - 1)) st <= S_RDY;
               else cnt <= cnt + 1'b1;
        default: st <= S_RDY;
      endcase
    end
  end

  always_comb begin
    case (bl_r)
      4'd2:    bl_code = 3'b001;
      4'd4:    bl_code = 3'b010;
      default: bl_code = 3'b011;
    endcase
    case (cas_r)
      3'd3:    cas_code = 3'b101;
      3'd4:    cas_code = 3'b010;
      3'd5:    cas_code = 3'b110;
      default: cas_code = 3'b011;
    endcase
  end

  assign slot = (st == S_SEQ) && (cnt == '0);

  always_comb begin
    {mem_ras_n, mem_cas_n, mem_we_n} = 3'b111;
    mem_ba   = 2'b00;
    mem_addr = '0;
    if (slot) begin
      case (step)
        3'd1, 3'd4: begin
          {mem_ras_n, mem_cas_n, mem_we_n} = 3'b010;
          mem_addr[10] = 1'b1;
        end
        3'd2: begin
          {mem_ras_n, mem_cas_n, mem_we_n} = 3'b000;
          mem_ba = 2'b01;
        end
        3'd3, 3'd7: begin
          {mem_ras_n, mem_cas_n, mem_we_n} = 3'b000;
          mem_addr[2:0] = bl_code;
          mem_addr[6:4] = cas_code;
          mem_addr[8]   = (step == 3'd3);
        end
        3'd5, 3'd6: {mem_ras_n, mem_cas_n, mem_we_n} = 3'b001;
        default: ;
      endcase
    end
  end

  assign mem_cke    = (st == S_SEQ) || (st == S_DLL) || (st == S_RDY);
  assign init_ready = (st == S_RDY);
  assign usr_grant  = usr_req && init_ready;
  assign usr_reject = usr_req && !init_ready;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W  = 13,
  parameter int CMD_GAP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usr_req,
  input logic              usr_grant,
  input logic              usr_reject,
  input logic              init_ready,
  input logic              mem_cke,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [1:0]        mem_ba,
  input logic [ADDR_W-1:0] mem_addr
);
  logic nop, base_mrs;
  assign nop      = {mem_ras_n, mem_cas_n, mem_we_n} == 3'b111;
  assign base_mrs = {mem_ras_n, mem_cas_n, mem_we_n} == 3'b000 && mem_ba == 2'b00;

  a_r3_quiet_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> nop);
  a_r3_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke);
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |=> init_ready);
  a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |-> nop);
  a_r9_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    usr_grant |-> (init_ready && usr_req && !usr_reject));
  a_r9_reject_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_req && !init_ready) |-> usr_reject);
  a_r6_bl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    base_mrs |-> (mem_addr[2:0] inside {3'b001, 3'b010, 3'b011} && !mem_addr[3]));
  a_r7_cas_legal: assert property (@(posedge clk) disable iff (!rst_n)
    base_mrs |-> (mem_addr[6:4] inside {3'b010, 3'b011, 3'b101, 3'b110}));

  generate
    if (CMD_GAP > 1) begin : g_gap
      a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        !nop |=> nop);
    end
  endgenerate
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .CMD_GAP(CMD_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_grant(usr_grant),
  .usr_reject(usr_reject), .init_ready(init_ready), .mem_cke(mem_cke),
  .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .mem_ba(mem_ba), .mem_addr(mem_addr)
);

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
  localparam int AW = 13;
  localparam int P  = 60;
  localparam int G  = 3;
  localparam int D  = 200;
  localparam int RDY_K = P + 8*G + D;
  localparam int END_K = RDY_K + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic usr_req = 1'b0;
  logic usr_grant, usr_reject, init_ready, mem_cke, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0] mem_ba;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.ADDR_W(AW), .PWR_CYC(P), .CMD_GAP(G), .DLL_CYC(D)) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .usr_req(usr_req),
    .usr_grant(usr_grant), .usr_reject(usr_reject), .init_ready(init_ready),
    .mem_cke(mem_cke), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr));

  function automatic logic [2:0] bl_enc(input logic [3:0] b);
    return (b == 4'd2) ? 3'b001 : (b == 4'd4) ? 3'b010 : 3'b011;
  endfunction

  function automatic logic [2:0] cas_enc(input logic [2:0] c);
    return (c == 3'd3) ? 3'b101 : (c == 3'd4) ? 3'b010 : (c == 3'd5) ? 3'b110 : 3'b011;
  endfunction

  function automatic int step_at(input int k);
    if (k < P || ((k - P) % G) != 0) return 0;
    if ((k - P) / G < 1 || (k - P) / G > 7) return 0;
    return (k - P) / G;
  endfunction

  // {cke, ras_n, cas_n, we_n, ba, addr, ready}
  function automatic logic [63:0] exp_vec(input int k, input logic [3:0] b, input logic [2:0] c);
    logic [2:0] cmd = 3'b111;
    logic [1:0] ba = 2'b00;
    logic [AW-1:0] a = '0;
    int s = step_at(k);
    case (s)
      1, 4: begin cmd = 3'b010; a[10] = 1'b1; end
      2:    begin cmd = 3'b000; ba = 2'b01; end
      3, 7: begin cmd = 3'b000; a[2:0] = bl_enc(b); a[6:4] = cas_enc(c); a[8] = (s == 3); end
      5, 6: cmd = 3'b001;
      default: ;
    endcase
    return 64'({(k >= P), cmd, ba, a, (k >= RDY_K)});
  endfunction

  function automatic logic [63:0] act_vec();
    return 64'({mem_cke, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr, init_ready});
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] b, input logic [2:0] c);
    logic [63:0] idle_v = 64'({1'b0, 3'b111, 2'b00, {AW{1'b0}}, 1'b0});
    rst_n = 1'b0; cfg_wr = 1'b0; usr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", act_vec(), idle_v);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", act_vec(), idle_v);
    // R2: write without start bit
    cfg_data = {1'b0, 3'($urandom), 4'($urandom)};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    usr_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2 no start", act_vec(), idle_v);
      chk("R9 reject idle", 64'({usr_grant, usr_reject}), 64'({1'b0, 1'b1}));
    end
    cfg_data = {1'b1, c, b};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int k = 0; k <= END_K; k++) begin
      int s = step_at(k);
      string tag = (k < P) ? "R3" : (k >= RDY_K) ? "R8 R10" :
                   (s == 3 || s == 7) ? "R6 R7 R10" : "R4 R5";
      chk(tag, act_vec(), exp_vec(k, b, c));
      chk("R9", 64'({usr_grant, usr_reject}), 64'({usr_req && (k >= RDY_K), usr_req && (k < RDY_K)}));
      usr_req = 1'($urandom);
      cfg_wr = (k == P + G + 1) || (k == 2) || (k == END_K - 3);
      cfg_data = {1'b1, ~c, ~b};
      @(negedge clk);
    end
    cfg_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    run(4'd2, 3'd3);
    run(4'd4, 3'd4);
    run(4'd8, 3'd5);
    run(4'd8, 3'd6);
    run(4'd5, 3'd7);
    for (int r = 0; r < 3; r++) run(4'($urandom), 3'($urandom));
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule